// File: doc/BRIEF.md
# Interconnect Error Detect and Capture Unit

This block sits beside an on-chip coherent interconnect and turns two classes of error event into software-visible state. Class 0 is a local access window error and class 1 is a coherency violation. Each event pulse arrives together with the faulting 40-bit address, an 8-bit source ID, a 5-bit capture type code and an unavailable-target qualifier. The block keeps a sticky flag for each class and records the details of the first error only. It drives a level interrupt while an enabled error is pending.

Software uses a single-cycle 32-bit register port to read status, acknowledge errors and program the enables. The write has effect at the clock edge, and read data is combinational from the word address. The parameter `NEWER` picks one of two register conventions. With `NEWER=1`, the control word suppresses detection and a separate interrupt-enable word gates the interrupt. With `NEWER=0`, the control word enables detection and also gates the interrupt. The two conventions also place the capture-valid flag and the source ID field at different bit positions.

Top module: `icx_err_report`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and `irq_o` is low.
- R2: Word select is `reg_addr_i[4:2]`: 0 detect, 1 control, 2 interrupt enable, 3 capture attribute, 4 address high, 5 address low, 6 capture attribute 2, and 7 reads zero. Address high holds captured address bits 39:32 in bits 7:0, and address low holds bits 31:0.
- R3: In the detect, control and interrupt-enable words, bit 0 is class 0 (access window error) and bit 1 is class 1 (coherency violation). A class is detected when its event pulses and it is allowed. With `NEWER=1` it is allowed when its control bit is 0, and with `NEWER=0` it is allowed when its control bit is 1.
- R4: A detect flag stays set until software writes 1 to its bit in the detect word. Writing 0 to a bit leaves that flag unchanged.
- R5: When capture is not valid, the first detected error loads the address, source ID, type, the detected class bits and (when class 0 is detected) the unavailable-target qualifier, and then sets capture-valid. While capture is valid, later errors set flags but change none of the captured fields.
- R6: With `NEWER=1`, the detect word shows capture-valid in bit 31 and the type in bits 30:26, and the attribute word shows the source ID in bits 25:18. With `NEWER=0`, the attribute word shows the source ID in bits 31:24, the unavailable-target qualifier in bit 15 and capture-valid in bit 0. Capture attribute 2 shows the type in bits 12:8 and the captured class bits in bits 1:0.
- R7: Capture-valid is cleared by writing 1 to detect bit 31 when `NEWER=1`, and by writing 1 to attribute bit 0 when `NEWER=0`.
- R8: With `NEWER=1`, `irq_o` is the OR of the detect flags ANDed with the interrupt-enable bits. With `NEWER=0`, it is the OR of the flags ANDed with the control bits, and the interrupt-enable word reads zero and ignores writes.
- R9: A detect write that clears every pending flag drops `irq_o` in the next cycle, unless a new event arrives in the write cycle.
- R10: Writes to the attribute, address and attribute-2 words change nothing, except the `NEWER=0` valid clear in R7.
- R11: If an event is detected in the same cycle as a write that clears its flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lae_evt_i | input | 1 | Access window error event pulse (class 0) |
| cv_evt_i | input | 1 | Coherency violation event pulse (class 1) |
| evt_addr_i | input | 40 | Faulting address qualifying the event |
| evt_src_i | input | 8 | Source ID qualifying the event |
| evt_type_i | input | 5 | Capture type code qualifying the event |
| evt_uvt_i | input | 1 | Unavailable target qualifier for class 0 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that the event pulses and their qualifiers are stable across each clock edge, and that reset is seen synchronously. The interrupt-drop property assumes that no event arrives in the same cycle as the clearing write. The bench drives every input 2 ns after a rising edge, so all inputs are settled before the next edge. In its directed R9 step it keeps both event inputs low during the clearing write. The pseudo-random phase does allow events and writes to coincide, and there the drop property simply does not apply. One stimulus stream feeds one instance of each convention, and a behavioural model of each convention is compared against the outputs at every falling edge.

// File: rtl/icx_err_pkg.sv
// Package: shared constants and the register write record for the
// interconnect error unit. Assumes a 32-bit register port.
package icx_err_pkg;

    localparam int REG_DW = 32;
    localparam int SEL_W  = 3;

    // word selects, taken from byte address bits [4:2]
    localparam logic [SEL_W-1:0] SEL_DET   = 3'd0;
    localparam logic [SEL_W-1:0] SEL_CTL   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_IEN   = 3'd2;
    localparam logic [SEL_W-1:0] SEL_ATTR  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_ADRH  = 3'd4;
    localparam logic [SEL_W-1:0] SEL_ADRL  = 3'd5;
    localparam logic [SEL_W-1:0] SEL_ATTR2 = 3'd6;

    // field positions that software decodes
    localparam int NEW_CAPV_BIT  = 31;
    localparam int NEW_TYPE_LSB  = 26;
    localparam int NEW_SRC_LSB   = 18;
    localparam int OLD_SRC_LSB   = 24;
    localparam int OLD_UVT_BIT   = 15;
    localparam int OLD_CAPV_BIT  = 0;
    localparam int A2_TYPE_LSB   = 8;
    localparam int FLD_SRC_W     = 8;
    localparam int FLD_TYPE_W    = 5;

    typedef struct packed {
        logic              en;
        logic [SEL_W-1:0]  sel;
        logic [REG_DW-1:0] data;
    } reg_wr_t;

endpackage

// File: rtl/icx_err_ctrl.sv
// Module: control and interrupt-enable registers. Converts the control
// word into per-class detection permits and selects the interrupt mask
// for the chosen convention. Assumes CLS_N <= 32.
module icx_err_ctrl
    import icx_err_pkg::*;
#(
    parameter bit NEWER = 1'b1,
    parameter int CLS_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  reg_wr_t          wr,
    output logic [CLS_N-1:0] ctl_q,
    output logic [CLS_N-1:0] ien_q,
    output logic [CLS_N-1:0] det_allow,
    output logic [CLS_N-1:0] irq_mask
);

    logic ctl_wr;
    assign ctl_wr = wr.en && (wr.sel == SEL_CTL);

    // control word register, loaded by a write to its select
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_wr) ctl_q <= wr.data[CLS_N-1:0];
    end

    generate
        if (NEWER) begin : g_new
            logic ien_wr;
            assign ien_wr = wr.en && (wr.sel == SEL_IEN);

            // interrupt-enable register, present only in this convention
            always_ff @(posedge clk) begin
                if (!rst_n)      ien_q <= '0;
                else if (ien_wr) ien_q <= wr.data[CLS_N-1:0];
            end

            // control bits suppress detection; separate interrupt mask
            always_comb begin
                det_allow = ~ctl_q;
                irq_mask  = ien_q;
            end
        end else begin : g_old
            // control bits enable detection and gate the interrupt
            always_comb begin
                ien_q     = '0;
                det_allow = ctl_q;
                irq_mask  = ctl_q;
            end
        end
    endgenerate

    assert_ctl_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> ctl_q == $past(wr.data[CLS_N-1:0]));

endmodule

// File: rtl/icx_err_capture.sv
// Module: sticky per-class detect flags with write-one-to-clear, and the
// first-error capture record with its valid flag. Assumes event inputs
// and their qualifiers are valid in the cycle the pulse is high.
module icx_err_capture
    import icx_err_pkg::*;
#(
    parameter bit NEWER  = 1'b1,
    parameter int CLS_N  = 2,
    parameter int ADDR_W = 40,
    parameter int SRC_W  = 8,
    parameter int TYPE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CLS_N-1:0]  evt,
    input  logic [CLS_N-1:0]  det_allow,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic [SRC_W-1:0]  evt_src,
    input  logic [TYPE_W-1:0] evt_type,
    input  logic              evt_uvt,
    input  reg_wr_t           wr,
    output logic [CLS_N-1:0]  flags_q,
    output logic              cap_valid_q,
    output logic [ADDR_W-1:0] cap_addr_q,
    output logic [SRC_W-1:0]  cap_src_q,
    output logic [TYPE_W-1:0] cap_type_q,
    output logic              cap_uvt_q,
    output logic [CLS_N-1:0]  cap_cls_q
);

    logic [CLS_N-1:0] det;
    logic [CLS_N-1:0] clr_flags;
    logic             clr_cap;
    logic             take;

    // qualify events with their detection permits
    always_comb begin
        det       = evt & det_allow;
        clr_flags = (wr.en && wr.sel == SEL_DET) ? wr.data[CLS_N-1:0] : '0;
        take      = !cap_valid_q && (|det);
    end

    // valid-clear position depends on the convention
    generate
        if (NEWER) begin : g_clr_new
            assign clr_cap = wr.en && (wr.sel == SEL_DET) && wr.data[NEW_CAPV_BIT];
        end else begin : g_clr_old
            assign clr_cap = wr.en && (wr.sel == SEL_ATTR) && wr.data[OLD_CAPV_BIT];
        end
    endgenerate

    // one sticky flag per class; a new detection beats a clear
    for (genvar k = 0; k < CLS_N; k++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)          flags_q[k] <= 1'b0;
            else if (det[k])     flags_q[k] <= 1'b1;
            else if (clr_flags[k]) flags_q[k] <= 1'b0;
        end

        assert_flag_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
            det[k] |=> flags_q[k]);

        assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[k] && !(wr.en && wr.sel == SEL_DET && wr.data[k])) |=> flags_q[k]);
    end

    // capture valid: set by the first error, cleared by software
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_valid_q <= 1'b0;
        else if (take)    cap_valid_q <= 1'b1;
        else if (clr_cap) cap_valid_q <= 1'b0;
    end

    // capture record: loaded only when no capture is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr_q <= '0;
            cap_src_q  <= '0;
            cap_type_q <= '0;
            cap_uvt_q  <= 1'b0;
            cap_cls_q  <= '0;
        end else if (take) begin
            cap_addr_q <= evt_addr;
            cap_src_q  <= evt_src;
            cap_type_q <= evt_type;
            cap_uvt_q  <= evt_uvt && det[0];
            cap_cls_q  <= det;
        end
    end

    assert_first_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid_q |=> ($stable(cap_addr_q) && $stable(cap_src_q) && $stable(cap_type_q)));

    assert_capture_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|det) |=> cap_valid_q || $past(cap_valid_q));

endmodule

// File: rtl/icx_err_regmux.sv
// Module: read-data formatting. Packs flags, enables and the capture
// record into the word layout of the chosen convention. Purely
// combinational; assumes ADDR_W is between 33 and 64.
module icx_err_regmux
    import icx_err_pkg::*;
#(
    parameter bit NEWER  = 1'b1,
    parameter int CLS_N  = 2,
    parameter int ADDR_W = 40,
    parameter int SRC_W  = 8,
    parameter int TYPE_W = 5
) (
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic [CLS_N-1:0]  flags_q,
    input  logic [CLS_N-1:0]  ctl_q,
    input  logic [CLS_N-1:0]  ien_q,
    input  logic              cap_valid_q,
    input  logic [ADDR_W-1:0] cap_addr_q,
    input  logic [SRC_W-1:0]  cap_src_q,
    input  logic [TYPE_W-1:0] cap_type_q,
    input  logic              cap_uvt_q,
    input  logic [CLS_N-1:0]  cap_cls_q,
    output logic [REG_DW-1:0] rdata
);

    localparam int HI_W = ADDR_W - 32;

    logic [REG_DW-1:0] w_det, w_attr, w_attr2, w_adrh, w_adrl;
    logic [FLD_SRC_W-1:0]  src_f;
    logic [FLD_TYPE_W-1:0] type_f;

    // fit captured fields into their fixed-width register fields
    always_comb begin
        src_f   = FLD_SRC_W'(cap_src_q);
        type_f  = FLD_TYPE_W'(cap_type_q);
        w_adrl  = cap_addr_q[31:0];
        w_adrh  = '0;
        w_adrh[HI_W-1:0] = cap_addr_q[ADDR_W-1:32];
        w_attr2 = '0;
        w_attr2[A2_TYPE_LSB +: FLD_TYPE_W] = type_f;
        w_attr2[CLS_N-1:0] = cap_cls_q;
    end

    // convention-specific placement of valid, type, source and qualifier
    generate
        if (NEWER) begin : g_new
            always_comb begin
                w_det = '0;
                w_det[CLS_N-1:0] = flags_q;
                w_det[NEW_CAPV_BIT] = cap_valid_q;
                w_det[NEW_TYPE_LSB +: FLD_TYPE_W] = type_f;
                w_attr = '0;
                w_attr[NEW_SRC_LSB +: FLD_SRC_W] = src_f;
            end
            logic unused_new;
            assign unused_new = cap_uvt_q;
        end else begin : g_old
            always_comb begin
                w_det = '0;
                w_det[CLS_N-1:0] = flags_q;
                w_attr = '0;
                w_attr[OLD_SRC_LSB +: FLD_SRC_W] = src_f;
                w_attr[OLD_UVT_BIT]  = cap_uvt_q;
                w_attr[OLD_CAPV_BIT] = cap_valid_q;
            end
        end
    endgenerate

    // word select
    always_comb begin
        rdata = '0;
        case (rd_sel)
            SEL_DET:   rdata = w_det;
            SEL_CTL:   rdata[CLS_N-1:0] = ctl_q;
            SEL_IEN:   rdata[CLS_N-1:0] = ien_q;
            SEL_ATTR:  rdata = w_attr;
            SEL_ADRH:  rdata = w_adrh;
            SEL_ADRL:  rdata = w_adrl;
            SEL_ATTR2: rdata = w_attr2;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/icx_err_report.sv
// Module: top of the interconnect error detect and capture unit. Wires
// the control registers, flag/capture store and read formatter, and
// drives the level interrupt. Assumes single-cycle register writes.
module icx_err_report
    import icx_err_pkg::*;
#(
    parameter bit NEWER  = 1'b1,
    parameter int ADDR_W = 40,
    parameter int SRC_W  = 8,
    parameter int TYPE_W = 5,
    parameter int RA_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lae_evt_i,
    input  logic              cv_evt_i,
    input  logic [ADDR_W-1:0] evt_addr_i,
    input  logic [SRC_W-1:0]  evt_src_i,
    input  logic [TYPE_W-1:0] evt_type_i,
    input  logic              evt_uvt_i,
    input  logic              reg_we_i,
    input  logic [RA_W-1:0]   reg_addr_i,
    input  logic [REG_DW-1:0] reg_wdata_i,
    output logic [REG_DW-1:0] reg_rdata_o,
    output logic              irq_o
);

    localparam int CLS_N = 2;

    reg_wr_t           wr;
    logic [SEL_W-1:0]  sel;
    logic [CLS_N-1:0]  evt, ctl_q, ien_q, det_allow, irq_mask, flags_q, cap_cls_q;
    logic              cap_valid_q, cap_uvt_q;
    logic [ADDR_W-1:0] cap_addr_q;
    logic [SRC_W-1:0]  cap_src_q;
    logic [TYPE_W-1:0] cap_type_q;

    // gather the port-level write and event buses
    always_comb begin
        sel     = reg_addr_i[2 +: SEL_W];
        wr.en   = reg_we_i;
        wr.sel  = sel;
        wr.data = reg_wdata_i;
        evt     = {cv_evt_i, lae_evt_i};
    end

    logic unused_addr_lsb;
    assign unused_addr_lsb = ^reg_addr_i[1:0];

    icx_err_ctrl #(.NEWER(NEWER), .CLS_N(CLS_N)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(wr),
        .ctl_q(ctl_q), .ien_q(ien_q), .det_allow(det_allow), .irq_mask(irq_mask)
    );

    icx_err_capture #(.NEWER(NEWER), .CLS_N(CLS_N), .ADDR_W(ADDR_W),
                      .SRC_W(SRC_W), .TYPE_W(TYPE_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .evt(evt), .det_allow(det_allow),
        .evt_addr(evt_addr_i), .evt_src(evt_src_i), .evt_type(evt_type_i),
        .evt_uvt(evt_uvt_i), .wr(wr),
        .flags_q(flags_q), .cap_valid_q(cap_valid_q), .cap_addr_q(cap_addr_q),
        .cap_src_q(cap_src_q), .cap_type_q(cap_type_q), .cap_uvt_q(cap_uvt_q),
        .cap_cls_q(cap_cls_q)
    );

    icx_err_regmux #(.NEWER(NEWER), .CLS_N(CLS_N), .ADDR_W(ADDR_W),
                     .SRC_W(SRC_W), .TYPE_W(TYPE_W)) u_mux (
        .rd_sel(sel), .flags_q(flags_q), .ctl_q(ctl_q), .ien_q(ien_q),
        .cap_valid_q(cap_valid_q), .cap_addr_q(cap_addr_q), .cap_src_q(cap_src_q),
        .cap_type_q(cap_type_q), .cap_uvt_q(cap_uvt_q), .cap_cls_q(cap_cls_q),
        .rdata(reg_rdata_o)
    );

    // level interrupt from pending, enabled flags
    assign irq_o = |(flags_q & irq_mask);

    assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && sel == SEL_DET && ((flags_q & ~reg_wdata_i[CLS_N-1:0]) == '0)
         && !lae_evt_i && !cv_evt_i) |=> !irq_o);

    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(lae_evt_i || cv_evt_i || reg_we_i));

endmodule

// File: tb/test_icx_err_report.sv
module test_icx_err_report;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lae, cv, uvt, we;
    logic [39:0] eaddr;
    logic [7:0]  esrc;
    logic [4:0]  etype;
    logic [4:0]  raddr;
    logic [31:0] wdata;
    logic [31:0] rd_new, rd_old;
    logic        irq_new, irq_old;

    int checks = 0, fails = 0, cycles = 0;
    string tag = "R1";
    bit chk_on = 0, done = 0;
    int rd_idx = 0;

    always #4 clk = ~clk;   // 125 MHz

    icx_err_report #(.NEWER(1'b1)) i_icx_err_report (
        .clk(clk), .rst_n(rst_n), .lae_evt_i(lae), .cv_evt_i(cv),
        .evt_addr_i(eaddr), .evt_src_i(esrc), .evt_type_i(etype), .evt_uvt_i(uvt),
        .reg_we_i(we), .reg_addr_i(raddr), .reg_wdata_i(wdata),
        .reg_rdata_o(rd_new), .irq_o(irq_new));

    icx_err_report #(.NEWER(1'b0)) i_icx_err_report_legacy (
        .clk(clk), .rst_n(rst_n), .lae_evt_i(lae), .cv_evt_i(cv),
        .evt_addr_i(eaddr), .evt_src_i(esrc), .evt_type_i(etype), .evt_uvt_i(uvt),
        .reg_we_i(we), .reg_addr_i(raddr), .reg_wdata_i(wdata),
        .reg_rdata_o(rd_old), .irq_o(irq_old));

    // behavioural model, index 0 = older convention, 1 = newer
    bit [1:0]  m_flags [2];
    bit [1:0]  m_ctl   [2];
    bit [1:0]  m_ien   [2];
    bit        m_cv    [2];
    bit        m_uvt   [2];
    bit [39:0] m_addr  [2];
    bit [7:0]  m_src   [2];
    bit [4:0]  m_type  [2];
    bit [1:0]  m_cls   [2];

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            for (int v = 0; v < 2; v++) begin
                m_flags[v] = 0; m_ctl[v] = 0; m_ien[v] = 0; m_cv[v] = 0; m_uvt[v] = 0;
                m_addr[v] = 0; m_src[v] = 0; m_type[v] = 0; m_cls[v] = 0;
            end
            chk_on = 1;
        end else begin
            for (int v = 0; v < 2; v++) begin
                bit [1:0] allow, det, clr;
                bit clrcap;
                int idx;
                idx = int'(raddr[4:2]);
                allow = (v == 1) ? ~m_ctl[v] : m_ctl[v];
                det = {cv, lae} & allow;
                clr = (we && idx == 0) ? wdata[1:0] : 2'b00;
                clrcap = (v == 1) ? (we && idx == 0 && wdata[31]) : (we && idx == 3 && wdata[0]);
                if (!m_cv[v] && det != 0) begin
                    m_cv[v] = 1; m_addr[v] = eaddr; m_src[v] = esrc; m_type[v] = etype;
                    m_uvt[v] = uvt && det[0]; m_cls[v] = det;
                end else if (clrcap) m_cv[v] = 0;
                m_flags[v] = det | (m_flags[v] & ~clr);
                if (we && idx == 1) m_ctl[v] = wdata[1:0];
                if (v == 1 && we && idx == 2) m_ien[v] = wdata[1:0];
            end
        end
    end

    function automatic logic [31:0] exp_rd(int v, int idx);
        case (idx)
            0: return (v == 1) ? {m_cv[v], m_type[v], 24'b0, m_flags[v]} : {30'b0, m_flags[v]};
            1: return {30'b0, m_ctl[v]};
            2: return {30'b0, m_ien[v]};
            3: return (v == 1) ? {6'b0, m_src[v], 18'b0}
                               : {m_src[v], 8'b0, m_uvt[v], 14'b0, m_cv[v]};
            4: return {24'b0, m_addr[v][39:32]};
            5: return m_addr[v][31:0];
            6: return {19'b0, m_type[v], 6'b0, m_cls[v]};
            default: return 32'b0;
        endcase
    endfunction

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h at cycle %0d",
                     tag, what, act, exp, cycles);
        end
    endtask

    // compare both instances against the model on every falling edge
    always @(negedge clk) begin
        if (chk_on && !done) begin
            int idx;
            idx = int'(raddr[4:2]);
            check($sformatf("new rdata[%0d]", idx), rd_new, exp_rd(1, idx));
            check($sformatf("old rdata[%0d]", idx), rd_old, exp_rd(0, idx));
            check("new irq", {31'b0, irq_new}, {31'b0, |(m_flags[1] & m_ien[1])});
            check("old irq", {31'b0, irq_old}, {31'b0, |(m_flags[0] & m_ctl[0])});
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cycles > 100000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    // one idle cycle that rotates the read address
    task automatic idle(int n = 1);
        for (int i = 0; i < n; i++) begin
            lae = 0; cv = 0; we = 0;
            raddr = 5'(rd_idx * 4);
            rd_idx = (rd_idx + 1) % 8;
            tick();
        end
    endtask

    task automatic sweep();
        idle(8);
    endtask

    task automatic wr(int idx, logic [31:0] d);
        we = 1; raddr = 5'(idx * 4); wdata = d;
        tick();
        we = 0;
    endtask

    task automatic event_pulse(bit l, bit c, logic [39:0] a, logic [7:0] s, logic [4:0] t, bit u);
        lae = l; cv = c; eaddr = a; esrc = s; etype = t; uvt = u; we = 0;
        tick();
        lae = 0; cv = 0;
    endtask

    initial begin
        logic [15:0] lf;
        rst_n = 0; lae = 0; cv = 0; uvt = 0; we = 0; raddr = 0; wdata = 0;
        eaddr = 0; esrc = 0; etype = 0;
        tag = "R1";
        repeat (3) tick();
        rst_n = 1;
        sweep();                                    // R1/R2 reset reads

        tag = "R3";                                 // new detects, old disabled
        event_pulse(1, 0, 40'hA5_1234_5678, 8'h3C, 5'h11, 0);
        tag = "R6"; sweep();

        tag = "R5";                                 // second error not captured
        event_pulse(0, 1, 40'h5A_8765_4321, 8'hC3, 5'h0E, 0);
        sweep();

        tag = "R8"; wr(2, 32'h3); sweep();
        tag = "R4"; wr(0, 32'h0); sweep();
        wr(0, 32'h1); sweep();

        tag = "R9"; wr(0, 32'h8000_0002); sweep();
        tag = "R7"; sweep();

        tag = "R3"; wr(1, 32'h3); sweep();          // new suppress, old enable
        event_pulse(1, 0, 40'hFF_0000_0001, 8'h77, 5'h1F, 1);
        tag = "R6"; sweep();

        tag = "R10";
        wr(4, 32'hFFFF_FFFF); wr(5, 32'hFFFF_FFFF); wr(6, 32'hFFFF_FFFF);
        wr(3, 32'hFFFF_FFFE); sweep();
        tag = "R7"; wr(3, 32'h1); sweep();

        tag = "R11"; wr(1, 32'h0);
        lae = 1; cv = 1; we = 1; raddr = 0; wdata = 32'h3; tick();
        lae = 0; cv = 0; we = 0; sweep();

        tag = "R2"; lf = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            lae = lf[0] & lf[5]; cv = lf[1] & lf[7];
            eaddr = {lf[7:0], lf, lf}; esrc = lf[15:8]; etype = lf[4:0]; uvt = lf[9];
            we = lf[3] & lf[11]; raddr = {lf[14:12], 2'b00}; wdata = {lf, lf};
            tick();
        end
        idle(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule